// File: doc/BRIEF.md
# Upper Memory Bank Switch Controller

This block sits between an 8-bit processor bus with a 16-bit address and a 64 KB RAM, with a ROM that overlays the top 12 KB of the address space. It holds a small configuration made of three bits. The first says whether upper RAM is write-protected. The second says whether reads of the upper region come from ROM. The third says which of two 4 KB RAM banks backs the lowest page of that region. A bus write to any of sixteen soft-switch addresses just above the I/O base reloads all three bits at once from the low four address bits. The data value on the bus plays no part.

On every bus cycle the block translates the processor address into a physical RAM address. It gates the RAM write enable and raises a read-source select when the data should come from ROM. The alternate bank of the $D000 page has no spare address bit of its own. It is folded onto physical page $C000, which the processor cannot otherwise reach as RAM because I/O sits there. The pages $E000 to $FFFF map one to one. The configuration is registered. The translation and gating are combinational, so a switch write affects accesses from the following cycle onward.

Top module: `upper_bank_ctl`

## Requirements
- R1: A cycle with bus_valid=1 and bus_wr=1 whose address lies in $C080–$C08F (upper twelve bits equal $C08) loads the configuration at that clock edge. The new value is visible on the cfg outputs from the next cycle. Reads of those addresses leave the configuration unchanged.
- R2: Address bit 3 of a switch write selects the bank for $D000–$DFFF. A 0 selects bank 2 (cfg_bank_alt=0) and a 1 selects bank 1 (cfg_bank_alt=1).
- R3: Address bits 1:0 of a switch write set the mode as follows. 00 gives cfg_rom_rd=0 and cfg_wr_prot=1. 01 gives cfg_rom_rd=1 and cfg_wr_prot=0. 10 gives cfg_rom_rd=1 and cfg_wr_prot=1. 11 gives cfg_rom_rd=0 and cfg_wr_prot=0.
- R4: Address bit 2 of a switch write has no effect. $C084–$C087 give the same configuration as $C080–$C083, and $C08C–$C08F give the same as $C088–$C08B.
- R5: While rst is high and after it falls, the configuration is cfg_rom_rd=1, cfg_wr_prot=0 and cfg_bank_alt=0.
- R6: For an access to $D000–$DFFF, ram_addr equals the address with bit 12 cleared (page $C) when cfg_bank_alt=1, and equals the address unchanged when cfg_bank_alt=0.
- R7: For addresses $E000–$FFFF, and for every address below $D000, ram_addr equals bus_addr whatever the configuration.
- R8: While cfg_wr_prot=1, ram_we stays 0 for every address in $D000–$FFFF. Writes below $D000, other than to switch addresses, still give ram_we=1.
- R9: While cfg_rom_rd=1 and cfg_wr_prot=0, a valid write to $D000–$FFFF gives ram_we=1.
- R10: rd_from_rom is 1 exactly when bus_valid=1, bus_addr is at least $D000 and cfg_rom_rd=1.
- R11: A valid access to any address outside $C080–$C08F, read or write, leaves all three configuration bits unchanged on the next cycle.
- R12: A write to a switch address gives ram_we=0 in that cycle. ram_we is also 0 whenever bus_valid=0 or bus_wr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_wr | input | 1 | Access is a write (1) or a read (0) |
| bus_addr | input | 16 | Processor address |
| ram_addr | output | 16 | Physical RAM address after bank folding |
| ram_we | output | 1 | RAM write enable for this cycle |
| rd_from_rom | output | 1 | Read data is to be taken from ROM |
| cfg_wr_prot | output | 1 | Upper RAM is write-protected |
| cfg_rom_rd | output | 1 | Upper-region reads are served from ROM |
| cfg_bank_alt | output | 1 | Bank 1 (folded onto page $C) backs $D000–$DFFF |

## Verification
Suppose the configuration register holds a wrong value. Then the exposed cfg bits differ from the expected ones one cycle after the offending switch write. The first later access to the upper region also shows a wrong RAM address, a wrong write enable or a wrong read source in that same cycle. If a decode fault lets a non-switch access reload the register, the cfg outputs move on the very next cycle. Random traffic that mixes switch writes with upper-region accesses therefore exposes such a fault within a few cycles.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

  // Width of the soft-switch select field taken from the low address bits
  localparam int SEL_W = 4;

  typedef struct packed {
    logic bank_alt;  // 1: bank 1, folded onto the page below the upper region
    logic rom_rd;    // 1: upper-region reads come from ROM
    logic wr_prot;   // 1: upper-region RAM writes are blocked
  } ubs_cfg_t;

  localparam ubs_cfg_t CFG_RESET = '{bank_alt: 1'b0, rom_rd: 1'b1, wr_prot: 1'b0};

  // Bit 3 picks the bank, bits 1:0 the mode, bit 2 is unused
  function automatic ubs_cfg_t decode_sel(input logic [SEL_W-1:0] sel);
    ubs_cfg_t c;
    c.bank_alt = sel[3];
    c.rom_rd   = sel[1] ^ sel[0];
    c.wr_prot  = ~sel[0];
    return c;
  endfunction

endpackage

// File: rtl/ubs_switch_decode.sv
module ubs_switch_decode
  import ubs_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
  input  logic              valid,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              upd,
  output ubs_cfg_t          nxt
);
  localparam int TAG_W = ADDR_W - SEL_W;
  localparam logic [TAG_W-1:0] SW_TAG = SW_BASE[ADDR_W-1:SEL_W];

  always_comb begin
    hit = (addr[ADDR_W-1:SEL_W] == SW_TAG);
    upd = valid & wr & hit;
    nxt = decode_sel(addr[SEL_W-1:0]);
  end
endmodule

// File: rtl/ubs_cfg_reg.sv
module ubs_cfg_reg
  import ubs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     upd,
  input  ubs_cfg_t nxt,
  output ubs_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)      cfg <= CFG_RESET;
    else if (upd) cfg <= nxt;
  end
endmodule

// File: rtl/ubs_addr_map.sv
module ubs_addr_map
  import ubs_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                PAGE_W     = 12,
  parameter logic [ADDR_W-1:0] UPPER_BASE = 16'hD000
) (
  input  logic              valid,
  input  logic              wr,
  input  logic              sw_hit,
  input  logic [ADDR_W-1:0] addr,
  input  ubs_cfg_t          cfg,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              rd_rom
);
  localparam int PTAG_W = ADDR_W - PAGE_W;
  localparam logic [PTAG_W-1:0] BANK_TAG = UPPER_BASE[ADDR_W-1:PAGE_W];
  localparam logic [PTAG_W-1:0] ALT_TAG  = BANK_TAG - PTAG_W'(1);

  logic in_upper;
  logic in_bank;

  always_comb begin
    in_upper = (addr >= UPPER_BASE);
    in_bank  = (addr[ADDR_W-1:PAGE_W] == BANK_TAG);
    if (in_bank && cfg.bank_alt) ram_addr = {ALT_TAG, addr[PAGE_W-1:0]};
    else                         ram_addr = addr;
    ram_we = valid & wr & ~sw_hit & ~(in_upper & cfg.wr_prot);
    rd_rom = valid & in_upper & cfg.rom_rd;
  end
endmodule

// File: rtl/upper_bank_ctl.sv
module upper_bank_ctl
  import ubs_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                PAGE_W     = 12,
  parameter logic [ADDR_W-1:0] SW_BASE    = 16'hC080,
  parameter logic [ADDR_W-1:0] UPPER_BASE = 16'hD000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              rd_from_rom,
  output logic              cfg_wr_prot,
  output logic              cfg_rom_rd,
  output logic              cfg_bank_alt
);
  logic     sw_hit;
  logic     sw_upd;
  ubs_cfg_t sw_nxt;
  ubs_cfg_t cfg_q;

  ubs_switch_decode #(.ADDR_W(ADDR_W), .SW_BASE(SW_BASE)) u_dec (
    .valid(bus_valid), .wr(bus_wr), .addr(bus_addr),
    .hit(sw_hit), .upd(sw_upd), .nxt(sw_nxt)
  );

  ubs_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .upd(sw_upd), .nxt(sw_nxt), .cfg(cfg_q)
  );

  ubs_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .UPPER_BASE(UPPER_BASE)) u_map (
    .valid(bus_valid), .wr(bus_wr), .sw_hit(sw_hit), .addr(bus_addr),
    .cfg(cfg_q), .ram_addr(ram_addr), .ram_we(ram_we), .rd_rom(rd_from_rom)
  );

  assign cfg_wr_prot  = cfg_q.wr_prot;
  assign cfg_rom_rd   = cfg_q.rom_rd;
  assign cfg_bank_alt = cfg_q.bank_alt;
endmodule

// File: rtl/ubs_checker.sv
module ubs_checker (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_wr,
  input logic [15:0] bus_addr,
  input logic [15:0] ram_addr,
  input logic        ram_we,
  input logic        rd_from_rom,
  input logic        cfg_wr_prot,
  input logic        cfg_rom_rd,
  input logic        cfg_bank_alt
);
  logic sw_wr;
  logic hi;
  assign sw_wr = bus_valid && bus_wr && (bus_addr[15:4] == 12'hC08);
  assign hi    = bus_addr[15:12] >= 4'hD;

  // R5
  a_r5_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rom_rd && !cfg_wr_prot && !cfg_bank_alt));

  // R2
  a_r2_bank_bit: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (cfg_bank_alt == $past(bus_addr[3])));

  // R3
  a_r3_mode_bits: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (cfg_wr_prot == !$past(bus_addr[0])) &&
              (cfg_rom_rd == ($past(bus_addr[1]) != $past(bus_addr[0]))));

  // R11
  a_r11_no_stray_update: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> $stable(cfg_wr_prot) && $stable(cfg_rom_rd) && $stable(cfg_bank_alt));

  // R8
  a_r8_protect: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_prot && hi) |-> !ram_we);

  // R6
  a_r6_fold: assert property (@(posedge clk) disable iff (rst)
    (cfg_bank_alt && bus_addr[15:12] == 4'hD) |-> (ram_addr == {4'hC, bus_addr[11:0]}));

  // R7
  a_r7_identity: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[15:12] != 4'hD) |-> (ram_addr == bus_addr));

  // R10
  a_r10_rom_sel: assert property (@(posedge clk) disable iff (rst)
    rd_from_rom |-> (bus_valid && hi && cfg_rom_rd));

  // R12
  a_r12_switch_no_we: assert property (@(posedge clk) disable iff (rst)
    sw_wr |-> !ram_we);
endmodule

bind upper_bank_ctl ubs_checker u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .ram_addr(ram_addr), .ram_we(ram_we),
  .rd_from_rom(rd_from_rom), .cfg_wr_prot(cfg_wr_prot),
  .cfg_rom_rd(cfg_rom_rd), .cfg_bank_alt(cfg_bank_alt)
);

// File: tb/sim_upper_bank_ctl.sv
`timescale 1ns/100ps
module sim_upper_bank_ctl;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid;
  logic        bus_wr;
  logic [15:0] bus_addr;
  logic [15:0] ram_addr;
  logic        ram_we;
  logic        rd_from_rom;
  logic        cfg_wr_prot;
  logic        cfg_rom_rd;
  logic        cfg_bank_alt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the configuration
  logic m_wp, m_rom, m_alt;

  always #2.5 clk = ~clk;

  upper_bank_ctl u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .ram_addr(ram_addr), .ram_we(ram_we),
    .rd_from_rom(rd_from_rom), .cfg_wr_prot(cfg_wr_prot),
    .cfg_rom_rd(cfg_rom_rd), .cfg_bank_alt(cfg_bank_alt)
  );

  function automatic logic is_sw(input logic [15:0] a);
    return a >= 16'hC080 && a <= 16'hC08F;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] a, input logic alt);
    if (alt && a >= 16'hD000 && a <= 16'hDFFF) return a - 16'h1000;
    return a;
  endfunction

  function automatic logic exp_we(input logic v, input logic w, input logic [15:0] a,
                                  input logic wp);
    if (!v || !w || is_sw(a)) return 1'b0;
    if (a >= 16'hD000 && wp) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h addr=%h", tag, act, exp, bus_addr);
    end
  endtask

  task automatic chk_cfg(input string tag);
    chk({tag, " wr_prot"}, {15'd0, cfg_wr_prot}, {15'd0, m_wp});
    chk({tag, " rom_rd"}, {15'd0, cfg_rom_rd}, {15'd0, m_rom});
    chk({tag, " bank_alt"}, {15'd0, cfg_bank_alt}, {15'd0, m_alt});
  endtask

  // One bus cycle: drive, check combinational outputs, clock, update model, check config
  task automatic step(input logic v, input logic w, input logic [15:0] a, input string tag);
    @(negedge clk);
    bus_valid = v; bus_wr = w; bus_addr = a;
    #1;
    chk({tag, " ram_addr R6/R7"}, ram_addr, exp_addr(a, m_alt));
    chk({tag, " ram_we R8/R9/R12"}, {15'd0, ram_we}, {15'd0, exp_we(v, w, a, m_wp)});
    chk({tag, " rd_from_rom R10"}, {15'd0, rd_from_rom},
        {15'd0, v && a >= 16'hD000 && m_rom});
    @(posedge clk);
    #1;
    if (v && w && is_sw(a)) begin
      m_alt = a[3];
      case (a[1:0])
        2'b00: begin m_rom = 1'b0; m_wp = 1'b1; end
        2'b01: begin m_rom = 1'b1; m_wp = 1'b0; end
        2'b10: begin m_rom = 1'b1; m_wp = 1'b1; end
        default: begin m_rom = 1'b0; m_wp = 1'b0; end
      endcase
    end
    chk_cfg({tag, " cfg R1/R11"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    rst = 1'b1; bus_valid = 1'b0; bus_wr = 1'b0; bus_addr = 16'h0000;
    m_wp = 1'b0; m_rom = 1'b1; m_alt = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_cfg("R5 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk_cfg("R5 after reset");

    // R5: reset config reads ROM and writes RAM in the upper region
    step(1'b1, 1'b1, 16'hFFFF, "R5 R9 write top");
    step(1'b1, 1'b0, 16'hD000, "R5 R10 read D000");

    // R1 R2 R3 R4: every switch address in turn
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b1, 16'hC080 + 16'(i), "R1 R2 R3 R4 switch sweep");
      step(1'b1, 1'b1, 16'hD123, "R6 R8 after switch");
    end

    // R1: read of switch address does not reload
    step(1'b1, 1'b1, 16'hC083, "R1 setup");
    step(1'b1, 1'b0, 16'hC088, "R1 read of switch");
    step(1'b0, 1'b1, 16'hC088, "R1 invalid write of switch");

    // R11: neighbours of the switch range
    step(1'b1, 1'b1, 16'hC07F, "R11 below range");
    step(1'b1, 1'b1, 16'hC090, "R11 above range");

    // R8: protected, bank 1; D page and top blocked, low memory still writable
    step(1'b1, 1'b1, 16'hC08A, "R8 setup");
    step(1'b1, 1'b1, 16'hD000, "R8 R6 blocked D000");
    step(1'b1, 1'b1, 16'hFFFF, "R8 R7 blocked FFFF");
    step(1'b1, 1'b1, 16'h1234, "R8 low write");
    step(1'b1, 1'b1, 16'hCFFF, "R7 page C pass");

    // R9: ROM read, writes allowed, bank 2
    step(1'b1, 1'b1, 16'hC085, "R9 R4 setup");
    step(1'b1, 1'b1, 16'hDFFF, "R9 write under ROM");
    step(1'b1, 1'b1, 16'hE000, "R9 R7 write E000");

    // R12: idle and read cycles never write
    step(1'b0, 1'b0, 16'h0200, "R12 idle");
    step(1'b1, 1'b0, 16'h0200, "R12 read");

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int unsigned r;
      r = $urandom % 4;
      case (r)
        0: a = 16'hC080 | 16'($urandom % 16);
        1: a = 16'hD000 | 16'($urandom % 4096);
        2: a = 16'hE000 | 16'($urandom % 8192);
        default: a = 16'($urandom);
      endcase
      step(($urandom % 8) != 0, $urandom % 2 == 1, a, "random R2 R3 R6 R7 R8 R10 R11");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule